// File: doc/BRIEF.md
# Instruction Prefix Scanner

The block walks the leading bytes of a variable-length instruction held in a byte window and sorts out its prefixes. A start pulse captures the window and a mode bit that selects 32-bit or 64-bit decoding. The scanner then looks at one byte per clock.

Segment-override, operand-size, address-size, lock and repeat prefixes are collected into four slots, and a repeated prefix is not stored twice. Each newly stored size prefix flips the effective operand or address size. When the legacy run ends, the most recent prefix byte is moved into the last slot. In 64-bit mode a single REX byte may follow. After that, a 2-byte or 3-byte VEX prefix is recognised.

When the scan completes, the block raises a one-cycle done pulse. At that point it presents the prefix count, the stored prefixes, the REX and VEX contents, the effective sizes and the offset of the first opcode byte. These results stay valid until the next start. An opcode decoder downstream uses the offset and the sizes to continue decoding.

Top module: `prefix_scan`

## Requirements
- R1: After reset, done_o is 0, the count and offset are 0, and both sizes read 4. On a start accepted while idle, every result is cleared. The operand size is set to 4, and the address size is set to 8 in 64-bit mode or 4 in 32-bit mode.
- R2: The bytes 0x26, 0x2E, 0x36, 0x3E, 0x64, 0x65, 0x66, 0x67, 0xF0, 0xF2 and 0xF3 are legacy prefixes. pfx_cnt_o counts every legacy byte consumed, and opc_ofs_o is the byte index just past all consumed prefixes.
- R3: A legacy byte equal to one already stored is counted but not stored again, and it does not change either size.
- R4: When a fifth distinct legacy byte appears with four already stored, scanning stops before that byte and invalid_o is set. No REX or VEX is then decoded, and opc_ofs_o equals pfx_cnt_o.
- R5: Each newly stored 0x66 XORs the operand size with 6 (4 and 2). Each newly stored 0x67 XORs the address size with 12 in 64-bit mode (8 and 4) or with 6 in 32-bit mode (4 and 2).
- R6: Slots fill in order of first appearance, with slot k in pfx_slots_o[8k+7:8k]. When the scan ends, if the last legacy byte seen differs from slot 3, that byte is written into slot 3. If slot 3 was non-zero before this write, its old byte replaces the last-seen byte in slots 0 to 2.
- R7: Only in 64-bit mode, a byte 0x40 to 0x4F directly after the legacy run is consumed as REX: rex_valid_o is 1 and rex_o holds the byte. If its bit 3 is set, the operand size becomes 8.
- R8: The lead byte 0xC5 starts a 2-byte VEX prefix and 0xC4 starts a 3-byte one. vex_o holds the lead byte in [7:0], the next byte in [15:8] and the third byte in [23:16] (0 for the 2-byte form). In 32-bit mode the lead byte is taken as VEX only if bits [7:6] of the following byte are 11.
- R9: For a 3-byte VEX in 64-bit mode, bit 7 of its third byte forces the operand size to 8.
- R10: An instruction is limited to 15 bytes. If the legacy run reaches index 15, scanning stops with invalid_o set. A REX or VEX prefix is consumed only if it ends within the first 15 bytes.
- R11: The scanner spends one clock per legacy byte, plus one clock for the byte that ends the run. In 64-bit mode it then spends one clock on REX. It then spends one clock on VEX. done_o is asserted for one cycle after these clocks, and start_i and win_i are ignored until the scan finishes.
- R12: All results hold their values after done_o until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan (accepted when idle) |
| mode64_i | input | 1 | 1 selects 64-bit decoding, 0 selects 32-bit |
| win_i | input | WIN_BYTES*8 | Instruction bytes, byte i in bits [8i+7:8i] |
| done_o | output | 1 | One-cycle pulse when results are ready |
| invalid_o | output | 1 | Too many distinct prefixes or length limit reached |
| pfx_cnt_o | output | $clog2(MAX_LEN+1) | Legacy prefix bytes consumed |
| pfx_slots_o | output | NSLOT*8 | Stored legacy prefixes |
| rex_valid_o | output | 1 | A REX byte was consumed |
| rex_o | output | 8 | REX byte |
| vex_len_o | output | 2 | VEX length: 0, 2 or 3 |
| vex_o | output | 24 | VEX bytes |
| opnd_size_o | output | 4 | Effective operand size in bytes |
| addr_size_o | output | 4 | Effective address size in bytes |
| opc_ofs_o | output | $clog2(MAX_LEN+1) | Index of first opcode byte |

## Verification
Every legacy run of up to three bytes, drawn from six prefixes that include both size prefixes, is tried. Each run is followed by one of six tails in both modes, and the results are compared against an arithmetic model. The runs tell apart first appearance from repetition (size toggles twice versus once) and the ordering rules of the slot-3 swap. The tails tell apart REX with and without W, the two VEX forms and the 32-bit mod-bit test. Directed cases cover the fifth distinct prefix, the 15-byte limit on legacy, REX and VEX bytes, a start pulse and window change during a scan, and holding results after done.

// File: rtl/prefix_scan_pkg.sv
package prefix_scan_pkg;

  typedef enum logic [2:0] {ST_IDLE, ST_LEG, ST_REX, ST_VEX, ST_DONE} scan_st_e;

  localparam logic [7:0] OPSZ_BYTE = 8'h66;
  localparam logic [7:0] ADSZ_BYTE = 8'h67;
  localparam logic [7:0] VEX3_LEAD = 8'hC4;
  localparam logic [7:0] VEX2_LEAD = 8'hC5;

  function automatic logic is_legacy(input logic [7:0] b);
    case (b)
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65,
      8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/prefix_class.sv
module prefix_class
  import prefix_scan_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic       legacy_o,
  output logic       opsz_o,
  output logic       adsz_o,
  output logic       rex_o
);
  assign legacy_o = is_legacy(byte_i);
  assign opsz_o   = byte_i == OPSZ_BYTE;
  assign adsz_o   = byte_i == ADSZ_BYTE;
  assign rex_o    = byte_i[7:4] == 4'h4;
endmodule

// File: rtl/vex_detect.sv
module vex_detect
  import prefix_scan_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          mode64_i,
  input  logic [7:0]    lead_i,
  input  logic [7:0]    mid_i,
  input  logic [7:0]    tail_i,
  input  logic [CW-1:0] room_i,
  output logic [1:0]    len_o,
  output logic          wide_o
);
  logic [1:0] raw_len;
  logic       mod_ok;

  assign mod_ok = mode64_i || (mid_i[7:6] == 2'b11);

  always_comb begin
    raw_len = 2'd0;
    if (lead_i == VEX3_LEAD)      raw_len = 2'd3;
    else if (lead_i == VEX2_LEAD) raw_len = 2'd2;
    if (!mod_ok || ({{(CW-2){1'b0}}, raw_len} > room_i)) raw_len = 2'd0;
  end

  assign len_o  = raw_len;
  assign wide_o = (raw_len == 2'd3) && mode64_i && tail_i[7];
endmodule

// File: rtl/prefix_slots.sv
module prefix_slots #(
  parameter int NSLOT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               push_i,
  input  logic               fix_i,
  input  logic [7:0]         byte_i,
  input  logic [7:0]         last_i,
  output logic               hit_o,
  output logic               full_o,
  output logic [NSLOT*8-1:0] slots_o
);
  localparam int NW  = $clog2(NSLOT + 1);
  localparam int TOP = NSLOT - 1;

  logic [7:0]       slot_q [NSLOT];
  logic [NW-1:0]    nb_q;
  logic [NSLOT-1:0] match;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign match[g]          = (NW'(g) < nb_q) && (slot_q[g] == byte_i);
    assign slots_o[g*8 +: 8] = slot_q[g];
  end

  assign hit_o  = |match;
  assign full_o = nb_q == NW'(NSLOT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nb_q <= '0;
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
    end else if (clear_i) begin
      nb_q <= '0;
      for (int i = 0; i < NSLOT; i++) slot_q[i] <= '0;
    end else if (push_i) begin
      for (int i = 0; i < NSLOT; i++)
        if (NW'(i) == nb_q) slot_q[i] <= byte_i;
      nb_q <= nb_q + NW'(1);
    end else if (fix_i && (last_i != 8'h00) && (last_i != slot_q[TOP])) begin
      // last-seen prefix goes to the top slot; old top takes its place
      for (int i = 0; i < TOP; i++)
        if ((slot_q[i] == last_i) && (slot_q[TOP] != 8'h00)) slot_q[i] <= slot_q[TOP];
      slot_q[TOP] <= last_i;
    end
  end
endmodule

// File: rtl/prefix_scan.sv
module prefix_scan
  import prefix_scan_pkg::*;
#(
  parameter int WIN_BYTES = 16,
  parameter int MAX_LEN   = 15,
  parameter int NSLOT     = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic                         mode64_i,
  input  logic [WIN_BYTES*8-1:0]       win_i,
  output logic                         done_o,
  output logic                         invalid_o,
  output logic [$clog2(MAX_LEN+1)-1:0] pfx_cnt_o,
  output logic [NSLOT*8-1:0]           pfx_slots_o,
  output logic                         rex_valid_o,
  output logic [7:0]                   rex_o,
  output logic [1:0]                   vex_len_o,
  output logic [23:0]                  vex_o,
  output logic [3:0]                   opnd_size_o,
  output logic [3:0]                   addr_size_o,
  output logic [$clog2(MAX_LEN+1)-1:0] opc_ofs_o
);
  localparam int CW = $clog2(MAX_LEN + 1);
  localparam int WW = WIN_BYTES * 8;

  scan_st_e        st_q;
  logic [WW-1:0]   win_q, win_sh;
  logic            m64_q;
  logic [CW-1:0]   ptr_q, cnt_q, room;
  logic [7:0]      last_q, b0, b1, b2;
  logic [3:0]      opnd_q, addr_q;
  logic            inv_q, rex_v_q;
  logic [7:0]      rex_q;
  logic [1:0]      vlen_q, vlen;
  logic [23:0]     vex_q;
  logic            is_leg, is_opsz, is_adsz, is_rex, vex_w;
  logic            hit, full, at_limit, in_leg;
  logic            take_leg, push, stop_leg, stop_bad, clear;

  assign win_sh = win_q >> {ptr_q, 3'b000};
  assign b0     = win_sh[7:0];
  assign b1     = win_sh[15:8];
  assign b2     = win_sh[23:16];
  assign room   = CW'(MAX_LEN) - ptr_q;

  prefix_class u_cls (
    .byte_i  (b0),
    .legacy_o(is_leg),
    .opsz_o  (is_opsz),
    .adsz_o  (is_adsz),
    .rex_o   (is_rex)
  );

  vex_detect #(.CW(CW)) u_vex (
    .mode64_i(m64_q),
    .lead_i  (b0),
    .mid_i   (b1),
    .tail_i  (b2),
    .room_i  (room),
    .len_o   (vlen),
    .wide_o  (vex_w)
  );

  assign in_leg   = st_q == ST_LEG;
  assign at_limit = ptr_q == CW'(MAX_LEN);
  assign take_leg = in_leg && !at_limit && is_leg && (hit || !full);
  assign push     = take_leg && !hit;
  assign stop_bad = in_leg && (at_limit || (is_leg && !hit && full));
  assign stop_leg = in_leg && !take_leg;
  assign clear    = (st_q == ST_IDLE) && start_i;

  prefix_slots #(.NSLOT(NSLOT)) u_slots (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(clear),
    .push_i (push),
    .fix_i  (stop_leg),
    .byte_i (b0),
    .last_i (last_q),
    .hit_o  (hit),
    .full_o (full),
    .slots_o(pfx_slots_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      win_q   <= '0;
      m64_q   <= 1'b0;
      ptr_q   <= '0;
      cnt_q   <= '0;
      last_q  <= '0;
      opnd_q  <= 4'd4;
      addr_q  <= 4'd4;
      inv_q   <= 1'b0;
      rex_v_q <= 1'b0;
      rex_q   <= '0;
      vlen_q  <= '0;
      vex_q   <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          win_q   <= win_i;
          m64_q   <= mode64_i;
          ptr_q   <= '0;
          cnt_q   <= '0;
          last_q  <= '0;
          opnd_q  <= 4'd4;
          addr_q  <= mode64_i ? 4'd8 : 4'd4;
          inv_q   <= 1'b0;
          rex_v_q <= 1'b0;
          rex_q   <= '0;
          vlen_q  <= '0;
          vex_q   <= '0;
          st_q    <= ST_LEG;
        end
        ST_LEG: begin
          if (take_leg) begin
            ptr_q  <= ptr_q + CW'(1);
            cnt_q  <= cnt_q + CW'(1);
            last_q <= b0;
            if (push && is_adsz) addr_q <= addr_q ^ (m64_q ? 4'd12 : 4'd6);
            if (push && is_opsz) opnd_q <= opnd_q ^ 4'd6;
          end else if (stop_bad) begin
            inv_q <= 1'b1;
            st_q  <= ST_DONE;
          end else begin
            st_q <= m64_q ? ST_REX : ST_VEX;
          end
        end
        ST_REX: begin
          if (is_rex && !at_limit) begin
            rex_v_q <= 1'b1;
            rex_q   <= b0;
            ptr_q   <= ptr_q + CW'(1);
            if (b0[3]) opnd_q <= 4'd8;
          end
          st_q <= ST_VEX;
        end
        ST_VEX: begin
          if (vlen != 2'd0) begin
            vlen_q <= vlen;
            vex_q  <= {(vlen == 2'd3) ? b2 : 8'h00, b1, b0};
            ptr_q  <= ptr_q + CW'(vlen);
            if (vex_w) opnd_q <= 4'd8;
          end
          st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o      = st_q == ST_DONE;
  assign invalid_o   = inv_q;
  assign pfx_cnt_o   = cnt_q;
  assign rex_valid_o = rex_v_q;
  assign rex_o       = rex_q;
  assign vex_len_o   = vlen_q;
  assign vex_o       = vex_q;
  assign opnd_size_o = opnd_q;
  assign addr_size_o = addr_q;
  assign opc_ofs_o   = ptr_q;
endmodule

// File: rtl/prefix_scan_chk.sv
module prefix_scan_chk #(
  parameter int MAX_LEN = 15
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         done_o,
  input logic                         invalid_o,
  input logic [$clog2(MAX_LEN+1)-1:0] pfx_cnt_o,
  input logic                         rex_valid_o,
  input logic [7:0]                   rex_o,
  input logic [1:0]                   vex_len_o,
  input logic [3:0]                   opnd_size_o,
  input logic [3:0]                   addr_size_o,
  input logic [$clog2(MAX_LEN+1)-1:0] opc_ofs_o
);
  localparam int CW = $clog2(MAX_LEN + 1);

  logic [CW+1:0] sum_ofs;
  assign sum_ofs = {2'b00, pfx_cnt_o} + {{(CW+1){1'b0}}, rex_valid_o} + {{CW{1'b0}}, vex_len_o};

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  opnd_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    opnd_size_o == 4'd2 || opnd_size_o == 4'd4 || opnd_size_o == 4'd8);

  // R5
  addr_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_size_o == 4'd2 || addr_size_o == 4'd4 || addr_size_o == 4'd8);

  // R8
  vex_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vex_len_o != 2'd1);

  // R2
  ofs_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !invalid_o) |-> (sum_ofs == {2'b00, opc_ofs_o}));

  // R4
  inv_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && invalid_o) |-> (opc_ofs_o == pfx_cnt_o && !rex_valid_o && vex_len_o == 2'd0));

  // R7
  rex_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rex_valid_o |-> rex_o[7:4] == 4'h4);

  // R12
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ($stable(opc_ofs_o) && $stable(opnd_size_o) && $stable(pfx_cnt_o)));
endmodule

bind prefix_scan prefix_scan_chk #(.MAX_LEN(MAX_LEN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .invalid_o  (invalid_o),
  .pfx_cnt_o  (pfx_cnt_o),
  .rex_valid_o(rex_valid_o),
  .rex_o      (rex_o),
  .vex_len_o  (vex_len_o),
  .opnd_size_o(opnd_size_o),
  .addr_size_o(addr_size_o),
  .opc_ofs_o  (opc_ofs_o)
);

// File: tb/prefix_scan_test.sv
module prefix_scan_test;
  localparam int CLK_PERIOD = 10;
  localparam int WB = 16;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         mode64_i = 1'b0;
  logic [WB*8-1:0] win_i = '0;
  logic         done_o, invalid_o, rex_valid_o;
  logic [3:0]   pfx_cnt_o, opc_ofs_o, opnd_size_o, addr_size_o;
  logic [31:0]  pfx_slots_o;
  logic [7:0]   rex_o;
  logic [1:0]   vex_len_o;
  logic [23:0]  vex_o;

  prefix_scan #(.WIN_BYTES(WB), .MAX_LEN(15), .NSLOT(4)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int nchk = 0, nfail = 0, lat;
  logic [7:0] wb [0:19];
  int  e_cnt, e_ofs, e_lat, e_opnd, e_addr, e_vlen;
  logic e_inv, e_rexv;
  logic [7:0] e_rex;
  logic [23:0] e_vex;
  logic [7:0] e_sl [0:3];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic leg(input logic [7:0] b);
    return b inside {8'h26, 8'h2E, 8'h36, 8'h3E, 8'h64, 8'h65, 8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3};
  endfunction

  task automatic model(input logic m64);
    int p = 0, nb = 0, len;
    logic [7:0] lb = 0;
    logic stop = 0, dup;
    e_cnt = 0; e_inv = 0; e_rexv = 0; e_rex = 0; e_vlen = 0; e_vex = 0;
    e_opnd = 4; e_addr = m64 ? 8 : 4;
    for (int i = 0; i < 4; i++) e_sl[i] = 0;
    while (!stop) begin
      if (p == 15) begin e_inv = 1; stop = 1; end
      else if (leg(wb[p])) begin
        dup = 0;
        for (int i = 0; i < nb; i++) if (e_sl[i] == wb[p]) dup = 1;
        if (!dup && nb == 4) begin e_inv = 1; stop = 1; end
        else begin
          if (!dup) begin
            e_sl[nb] = wb[p]; nb++;
            if (wb[p] == 8'h67) e_addr = e_addr ^ (m64 ? 12 : 6);
            if (wb[p] == 8'h66) e_opnd = e_opnd ^ 6;
          end
          e_cnt++; lb = wb[p]; p++;
        end
      end else stop = 1;
    end
    if (lb != 0 && lb != e_sl[3]) begin
      if (e_sl[3] != 0)
        for (int i = 0; i < 3; i++) if (e_sl[i] == lb) e_sl[i] = e_sl[3];
      e_sl[3] = lb;
    end
    if (e_inv) e_lat = e_cnt + 1;
    else begin
      e_lat = e_cnt + (m64 ? 3 : 2);
      if (m64 && wb[p][7:4] == 4'h4 && p < 15) begin
        e_rexv = 1; e_rex = wb[p];
        if (wb[p][3]) e_opnd = 8;
        p++;
      end
      len = (wb[p] == 8'hC4) ? 3 : (wb[p] == 8'hC5) ? 2 : 0;
      if (!m64 && wb[p+1][7:6] != 2'b11) len = 0;
      if (p + len > 15) len = 0;
      if (len != 0) begin
        e_vlen = len;
        e_vex = {(len == 3) ? wb[p+2] : 8'h00, wb[p+1], wb[p]};
        if (len == 3 && m64 && wb[p+2][7]) e_opnd = 8;
        p += len;
      end
    end
    e_ofs = p;
  endtask

  task automatic run(input logic m64, input logic glitch);
    model(m64);
    for (int i = 0; i < WB; i++) win_i[i*8 +: 8] = wb[i];
    mode64_i = m64;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 0;
    do begin
      if (glitch && lat == 1) begin
        start_i = 1'b1; win_i = {WB{8'h66}}; mode64_i = ~m64;
      end
      @(negedge clk_i);
      lat++;
    end while (!done_o && lat < 40);
    start_i = 1'b0;
    check("R11 latency", lat, e_lat);
    check("R2 count", pfx_cnt_o, e_cnt);
    check("R6 slots", pfx_slots_o, {e_sl[3], e_sl[2], e_sl[1], e_sl[0]});
    check("R7 rex", {rex_valid_o, rex_o}, {e_rexv, e_rex});
    check("R8/R9 vex", {vex_len_o, vex_o}, {e_vlen[1:0], e_vex});
    check("R5/R7/R9 opnd", opnd_size_o, e_opnd);
    check("R5 addr", addr_size_o, e_addr);
    check("R2 ofs", opc_ofs_o, e_ofs);
    check("R4/R10 invalid", invalid_o, e_inv);
    @(negedge clk_i);
  endtask

  task automatic clr();
    for (int i = 0; i < 20; i++) wb[i] = 8'h00;
  endtask

  initial begin : wd
    repeat (190000) @(posedge clk_i);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin : main
    logic [7:0] alpha [0:5] = '{8'h26, 8'h66, 8'h67, 8'hF3, 8'hF0, 8'h2E};
    logic [7:0] tl [0:5][0:3] = '{'{8'h90, 8'h00, 8'h00, 8'h00},
                                  '{8'h48, 8'h90, 8'h00, 8'h00},
                                  '{8'h41, 8'hC5, 8'hF8, 8'h77},
                                  '{8'hC4, 8'hE2, 8'hF9, 8'h90},
                                  '{8'hC5, 8'h3F, 8'h90, 8'h00},
                                  '{8'hC4, 8'hC1, 8'h79, 8'h90}};
    int pw;
    clr();
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 done", done_o, 0);
    check("R1 count", pfx_cnt_o, 0);
    check("R1 ofs", opc_ofs_o, 0);
    check("R1 sizes", {opnd_size_o, addr_size_o}, 8'h44);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // sweep: legacy runs of 0..3 bytes, six tails, both modes
    for (int n = 0; n <= 3; n++) begin
      pw = 1;
      for (int k = 0; k < n; k++) pw *= 6;
      for (int code = 0; code < pw; code++)
        for (int t = 0; t < 6; t++)
          for (int m = 0; m < 2; m++) begin
            int v = code;
            clr();
            for (int k = 0; k < n; k++) begin wb[k] = alpha[v % 6]; v /= 6; end
            for (int k = 0; k < 4; k++) wb[n+k] = tl[t][k];
            run(m[0], 1'b0);
          end
    end

    // R3: repeated operand-size prefix toggles once
    clr(); wb[0] = 8'h66; wb[1] = 8'h66; wb[2] = 8'h90;
    run(1'b0, 1'b0);
    check("R3 dup opnd", opnd_size_o, 2);
    check("R3 dup count", pfx_cnt_o, 2);

    // R4: fifth distinct prefix
    clr(); wb[0] = 8'h26; wb[1] = 8'h2E; wb[2] = 8'h36; wb[3] = 8'h3E; wb[4] = 8'h64; wb[5] = 8'h48;
    run(1'b1, 1'b0);
    check("R4 invalid", invalid_o, 1);
    check("R4 count", pfx_cnt_o, 4);

    // five bytes with a repeat stays valid; R6 swap with full slots
    clr(); wb[0] = 8'h26; wb[1] = 8'h2E; wb[2] = 8'h26; wb[3] = 8'h36; wb[4] = 8'h3E; wb[5] = 8'h2E; wb[6] = 8'h90;
    run(1'b0, 1'b0);
    check("R6 swap", pfx_slots_o, 32'h2E_36_3E_26);

    // R10: fifteen legacy bytes hit the limit
    clr(); for (int i = 0; i < 15; i++) wb[i] = 8'h2E; wb[15] = 8'h90;
    run(1'b1, 1'b0);
    check("R10 limit invalid", invalid_o, 1);
    check("R10 limit count", pfx_cnt_o, 15);

    // R10: REX fits at index 14, VEX after it does not
    clr(); for (int i = 0; i < 14; i++) wb[i] = 8'h2E; wb[14] = 8'h48; wb[15] = 8'hC5;
    run(1'b1, 1'b0);
    check("R10 rex fits", rex_valid_o, 1);
    check("R10 vex dropped", vex_len_o, 0);

    // R11: start and window change during scan are ignored
    clr(); wb[0] = 8'h67; wb[1] = 8'hF2; wb[2] = 8'h4C; wb[3] = 8'h90;
    run(1'b1, 1'b1);
    check("R11 ignore start addr", addr_size_o, 4);

    // R12: results hold after done
    repeat (4) @(negedge clk_i);
    check("R12 hold ofs", opc_ofs_o, e_ofs);
    check("R12 hold slots", pfx_slots_o, {e_sl[3], e_sl[2], e_sl[1], e_sl[0]});
    check("R12 no done", done_o, 0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule